// File: doc/BRIEF.md
# ATAPI Device-Side Interrupt and Drive-Select Controller

This block sits in the host-interface section of an ATAPI optical-drive controller. It tracks host writes to three task-file registers (Device Control, Drive Select, Command) and host reads of the Status register. From these it works out whether this drive is the one the host is addressing. It then raises two interrupts. The first is the host interrupt request pin on the IDE bus. The second is an active-low interrupt toward the local microprocessor.

Local firmware owns a control register with these bits: the interrupt enables, the drive-select enable, the master/slave choice and a host-interrupt-request bit. Firmware clears the pending host-interface event with either a status-read strobe or a clear-busy strobe. Two automatic sequences can also raise the host interrupt request flag with a completion pulse: packet transfer and status completion. The shadow-command status flag comes in from a neighbouring block, and this block only gates it with its enable.

Top module: `atapi_irq_ctrl`

## Requirements
- R1: After chip reset `hirq_pin` is 0, `uproc_irq_n` is 1, and `hif_pend`, `hirq_flag` and `drv_selected` are all 0.
- R2: `drv_selected` is 1 only when control bit 5 (select-enable, active low) is 0 and the last Drive Select write's bit 4 (DRV) equals the inverse of control bit 4 (master). So with master=1 the drive answers DRV=0, and with master=0 it answers DRV=1.
- R3: A Device Control write (reg code 0) with bit 2 (soft reset) at 1 sets `hif_pend` only when the previously written bit 2 was 0, whichever drive is selected. A repeated write of 1 does not set it.
- R4: A Command write (reg code 2) of opcode 90h sets `hif_pend` whether or not the drive is selected. Any other opcode sets it only while `drv_selected` is 1.
- R5: Opcode 08h never sets `hif_pend`. Opcode A0h does not set it while `apkt_en` is 1, and does set it (when selected) while `apkt_en` is 0.
- R6: `hif_pend` is cleared by `host_rst`, `loc_stat_rd` or `loc_clrbsy`. A clear in the same cycle as a set leaves it 0.
- R7: `hirq_pin` is 1 one cycle after `hirq_flag`=1, `drv_selected`=1 and the last Device Control bit 1 (interrupt disable) is 0 all hold. Otherwise it is 0.
- R8: A local control write loads `hirq_flag` from bit 3. A pulse on `pkt_done` or `stat_done` sets it.
- R9: `hirq_flag` is cleared by `host_rst`, by a Device Control write with bit 2 at 1, or, while selected, by any Command write or a Status read (reg code 3). Clear wins over a same-cycle set.
- R10: `uproc_irq_n` is 0, one cycle later, exactly when (`shdc_flag` and control bit 2) or (`hif_pend` and control bit 7) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous chip reset, active high |
| host_rst | input | 1 | Host reset pulse; clears both flags |
| host_wr | input | 1 | Host task-file write strobe |
| host_rd | input | 1 | Host task-file read strobe |
| host_reg | input | 2 | Register code: 0 DevCtl, 1 DrvSel, 2 Command, 3 Status |
| host_wdata | input | 8 | Host write data |
| loc_wr | input | 1 | Local control-register write strobe |
| loc_wdata | input | 8 | Local control-register data |
| loc_stat_rd | input | 1 | Local read of interrupt status; clears pending event |
| loc_clrbsy | input | 1 | Local clear-busy strobe; clears pending event |
| apkt_en | input | 1 | Automatic packet handling enabled |
| pkt_done | input | 1 | Packet-transfer sequence completion pulse |
| stat_done | input | 1 | Status-completion sequence completion pulse |
| shdc_flag | input | 1 | Shadow-command status flag |
| drv_selected | output | 1 | This drive is addressed |
| hif_pend | output | 1 | Host-interface event pending |
| hirq_flag | output | 1 | Internal host-interrupt-request flag |
| hirq_pin | output | 1 | Host interrupt request toward the bus |
| uproc_irq_n | output | 1 | Active-low interrupt toward the microprocessor |

## Verification
A stale soft-reset history bit shows up as a missing or an extra `hif_pend` on the next Device Control write, visible one cycle after the write. A wrong stored DRV or master decode flips `drv_selected` on the next cycle. That error then shows in the opcode filtering and in gating of `hirq_pin` one cycle further on. A wrong set/clear priority shows as a flag left at 1 right after a same-cycle collision. `uproc_irq_n` trails the flags by a single cycle, so any enable-bit mix-up shows within two cycles of the stimulus.

// File: rtl/atapi_irq_pkg.sv
package atapi_irq_pkg;
  localparam int DW = 8;
  localparam logic [1:0] TF_DEVCTL = 2'd0;
  localparam logic [1:0] TF_DRVSEL = 2'd1;
  localparam logic [1:0] TF_CMD    = 2'd2;
  localparam logic [1:0] TF_STATUS = 2'd3;
  // control register bit positions
  localparam int CB_HIIEN  = 7;
  localparam int CB_DSELN  = 5;
  localparam int CB_MASTER = 4;
  localparam int CB_HIRQ   = 3;
  localparam int CB_SHIEN  = 2;
  localparam logic [DW-1:0] CB_MASK = 8'hBC;
  // task-file bit positions
  localparam int DC_SRST = 2;
  localparam int DC_NIEN = 1;
  localparam int DS_DRV  = 4;
  // opcodes
  localparam logic [DW-1:0] OP_EXEMPT = 8'h08;
  localparam logic [DW-1:0] OP_PACKET = 8'hA0;
  localparam logic [DW-1:0] OP_DIAG   = 8'h90;
endpackage

// File: rtl/atapi_tf_track.sv
module atapi_tf_track
  import atapi_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  input  logic          dsel_en_n,
  input  logic          master,
  input  logic          apkt_en,
  output logic          selected,
  output logic          nien_on,
  output logic          hif_set,
  output logic          hirq_clr
);
  logic drv_q, srst_q, nien_q;
  logic wr_dc, wr_ds, wr_cmd, rd_st, op_counts;

  assign wr_dc  = host_wr && (host_reg == TF_DEVCTL);
  assign wr_ds  = host_wr && (host_reg == TF_DRVSEL);
  assign wr_cmd = host_wr && (host_reg == TF_CMD);
  assign rd_st  = host_rd && (host_reg == TF_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= 1'b0;
      srst_q <= 1'b0;
      nien_q <= 1'b0;
    end else begin
      if (wr_ds) drv_q <= host_wdata[DS_DRV];
      if (wr_dc) begin
        srst_q <= host_wdata[DC_SRST];
        nien_q <= host_wdata[DC_NIEN];
      end
    end
  end

  assign selected = !dsel_en_n && (drv_q == !master);
  assign nien_on  = !nien_q;

  assign op_counts = (host_wdata == OP_DIAG) ||
                     (selected && (host_wdata != OP_EXEMPT) &&
                      !((host_wdata == OP_PACKET) && apkt_en));

  assign hif_set  = (wr_dc && host_wdata[DC_SRST] && !srst_q) ||
                    (wr_cmd && op_counts);
  assign hirq_clr = (wr_dc && host_wdata[DC_SRST]) ||
                    (wr_cmd && selected) || (rd_st && selected);
endmodule

// File: rtl/atapi_irq_flags.sv
module atapi_irq_flags
  import atapi_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rst,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  input  logic          hif_set,
  input  logic          hif_clr,
  input  logic          hirq_set,
  input  logic          hirq_clr,
  output logic [DW-1:0] ctrl_q,
  output logic          hif_pend,
  output logic          hirq_flag
);
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (loc_wr) ctrl_q <= loc_wdata & CB_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst || host_rst)  hif_pend <= 1'b0;
    else if (hif_clr)     hif_pend <= 1'b0;
    else if (hif_set)     hif_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || host_rst)  hirq_flag <= 1'b0;
    else if (hirq_clr)    hirq_flag <= 1'b0;
    else if (loc_wr)      hirq_flag <= loc_wdata[CB_HIRQ];
    else if (hirq_set)    hirq_flag <= 1'b1;
  end

  AST_HRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    host_rst |=> (!hif_pend && !hirq_flag)); // R6
  AST_HIF_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    hif_clr |=> !hif_pend); // R6
  AST_HIRQ_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    hirq_clr |=> !hirq_flag); // R9
endmodule

// File: rtl/atapi_irq_drive.sv
module atapi_irq_drive (
  input  logic clk,
  input  logic rst,
  input  logic hirq_flag,
  input  logic selected,
  input  logic nien_on,
  input  logic shdc_flag,
  input  logic shien,
  input  logic hif_pend,
  input  logic hiien,
  output logic hirq_pin,
  output logic uproc_irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hirq_pin    <= 1'b0;
      uproc_irq_n <= 1'b1;
    end else begin
      hirq_pin    <= hirq_flag && selected && nien_on;
      uproc_irq_n <= !((shdc_flag && shien) || (hif_pend && hiien));
    end
  end

  AST_PIN_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    !selected |=> !hirq_pin); // R7
  AST_UIRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!hiien && !shien) |=> uproc_irq_n); // R10
endmodule

// File: rtl/atapi_irq_ctrl.sv
module atapi_irq_ctrl
  import atapi_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  input  logic          loc_stat_rd,
  input  logic          loc_clrbsy,
  input  logic          apkt_en,
  input  logic          pkt_done,
  input  logic          stat_done,
  input  logic          shdc_flag,
  output logic          drv_selected,
  output logic          hif_pend,
  output logic          hirq_flag,
  output logic          hirq_pin,
  output logic          uproc_irq_n
);
  logic [DW-1:0] ctrl_q;
  logic nien_on, hif_set, hirq_clr;

  atapi_tf_track u_track (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_reg(host_reg), .host_wdata(host_wdata),
    .dsel_en_n(ctrl_q[CB_DSELN]), .master(ctrl_q[CB_MASTER]),
    .apkt_en(apkt_en), .selected(drv_selected), .nien_on(nien_on),
    .hif_set(hif_set), .hirq_clr(hirq_clr)
  );

  atapi_irq_flags u_flags (
    .clk(clk), .rst(rst), .host_rst(host_rst), .loc_wr(loc_wr),
    .loc_wdata(loc_wdata), .hif_set(hif_set),
    .hif_clr(loc_stat_rd || loc_clrbsy),
    .hirq_set(pkt_done || stat_done), .hirq_clr(hirq_clr),
    .ctrl_q(ctrl_q), .hif_pend(hif_pend), .hirq_flag(hirq_flag)
  );

  atapi_irq_drive u_drive (
    .clk(clk), .rst(rst), .hirq_flag(hirq_flag), .selected(drv_selected),
    .nien_on(nien_on), .shdc_flag(shdc_flag), .shien(ctrl_q[CB_SHIEN]),
    .hif_pend(hif_pend), .hiien(ctrl_q[CB_HIIEN]),
    .hirq_pin(hirq_pin), .uproc_irq_n(uproc_irq_n)
  );

  AST_DIAG_ANY_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_reg == TF_CMD && host_wdata == OP_DIAG &&
     !loc_stat_rd && !loc_clrbsy && !host_rst) |=> hif_pend); // R4
  AST_EXEMPT_OP: assert property (@(posedge clk) disable iff (rst)
    (!hif_pend && host_wr && host_reg == TF_CMD && host_wdata == OP_EXEMPT)
      |=> !hif_pend); // R5
  AST_STATUS_RD_CLR: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_reg == TF_STATUS && drv_selected) |=> !hirq_flag); // R9
endmodule

// File: tb/atapi_irq_ctrl_bench.sv
module atapi_irq_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1, host_rst = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_reg = 2'd0;
  logic [7:0] host_wdata = 8'h00, loc_wdata = 8'h00;
  logic loc_wr = 1'b0, loc_stat_rd = 1'b0, loc_clrbsy = 1'b0;
  logic apkt_en = 1'b0, pkt_done = 1'b0, stat_done = 1'b0, shdc_flag = 1'b0;
  logic drv_selected, hif_pend, hirq_flag, hirq_pin, uproc_irq_n;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  atapi_irq_ctrl u_atapi_irq_ctrl (.*);

  // {opcode, DRV bit, apkt_en, expected hif_pend}; control = 90h (master, enables on)
  localparam logic [10:0] VEC [8] = '{
    {8'h90, 1'b1, 1'b0, 1'b1}, {8'h25, 1'b0, 1'b0, 1'b1},
    {8'h25, 1'b1, 1'b0, 1'b0}, {8'h08, 1'b0, 1'b0, 1'b0},
    {8'hA0, 1'b0, 1'b1, 1'b0}, {8'hA0, 1'b0, 1'b0, 1'b1},
    {8'h90, 1'b0, 1'b1, 1'b1}, {8'hEC, 1'b1, 1'b1, 1'b0}};

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] r, logic [7:0] d);
    host_wr = 1'b1; host_reg = r; host_wdata = d;
    tick(1); host_wr = 1'b0; tick(2);
  endtask

  task automatic hrd_status();
    host_rd = 1'b1; host_reg = 2'd3;
    tick(1); host_rd = 1'b0; tick(2);
  endtask

  task automatic lwr(logic [7:0] d);
    loc_wr = 1'b1; loc_wdata = d;
    tick(1); loc_wr = 1'b0; tick(2);
  endtask

  task automatic lclr(bit bsy);
    if (bsy) loc_clrbsy = 1'b1; else loc_stat_rd = 1'b1;
    tick(1); loc_clrbsy = 1'b0; loc_stat_rd = 1'b0; tick(2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 pin", hirq_pin, 1'b0);
    check("R1 uirq", uproc_irq_n, 1'b1);
    check("R1 hif", hif_pend, 1'b0);
    check("R1 flag", hirq_flag, 1'b0);
    check("R1 sel", drv_selected, 1'b0);
    rst = 1'b0; tick(1);

    // R2 selection decode
    lwr(8'h90); hwr(2'd1, 8'h00); check("R2 master DRV0", drv_selected, 1'b1);
    hwr(2'd1, 8'h10); check("R2 master DRV1", drv_selected, 1'b0);
    lwr(8'h80); check("R2 slave DRV1", drv_selected, 1'b1);
    lwr(8'hA0); check("R2 disabled", drv_selected, 1'b0);

    // R4 R5 table walk
    lwr(8'h90);
    for (int i = 0; i < 8; i++) begin
      lclr(0);
      hwr(2'd1, {3'b000, VEC[i][2], 4'h0});
      apkt_en = VEC[i][1];
      hwr(2'd2, VEC[i][10:3]);
      check("R4/R5 vec hif", hif_pend, VEC[i][0]);
      check("R10 vec uirq", uproc_irq_n, !VEC[i][0]);
    end
    apkt_en = 1'b0;

    // R3 soft-reset edge, drive not selected
    lclr(0); hwr(2'd1, 8'h10);
    hwr(2'd0, 8'h04); check("R3 first edge", hif_pend, 1'b1);
    lclr(0); check("R6 stat rd clears", hif_pend, 1'b0);
    hwr(2'd0, 8'h04); check("R3 repeat one", hif_pend, 1'b0);
    hwr(2'd0, 8'h00); hwr(2'd0, 8'h04); check("R3 new edge", hif_pend, 1'b1);
    lclr(1); check("R6 clrbsy clears", hif_pend, 1'b0);
    hwr(2'd0, 8'h00);

    // R6 host reset and same-cycle collision
    hwr(2'd2, 8'h90);
    host_rst = 1'b1; tick(1); host_rst = 1'b0; tick(2);
    check("R6 host reset", hif_pend, 1'b0);
    host_wr = 1'b1; host_reg = 2'd2; host_wdata = 8'h90; loc_stat_rd = 1'b1;
    tick(1); host_wr = 1'b0; loc_stat_rd = 1'b0; tick(2);
    check("R6 clear wins", hif_pend, 1'b0);

    // R7 R8 host interrupt pin
    hwr(2'd1, 8'h00); lwr(8'h98);
    check("R8 local load", hirq_flag, 1'b1);
    check("R7 pin on", hirq_pin, 1'b1);
    hwr(2'd0, 8'h02); check("R7 nIEN off", hirq_pin, 1'b0);
    check("R7 flag kept", hirq_flag, 1'b1);
    hwr(2'd0, 8'h00); check("R7 nIEN back", hirq_pin, 1'b1);
    hwr(2'd1, 8'h10); check("R7 unselected", hirq_pin, 1'b0);
    hrd_status(); check("R9 rd unselected keeps", hirq_flag, 1'b1);
    hwr(2'd1, 8'h00); hrd_status(); check("R9 rd selected clears", hirq_flag, 1'b0);
    pkt_done = 1'b1; tick(1); pkt_done = 1'b0; tick(2);
    check("R8 pkt_done", hirq_flag, 1'b1);
    hwr(2'd2, 8'h08); check("R9 cmd clears", hirq_flag, 1'b0);
    stat_done = 1'b1; tick(1); stat_done = 1'b0; tick(2);
    check("R8 stat_done", hirq_flag, 1'b1);
    hwr(2'd0, 8'h04); check("R9 srst clears", hirq_flag, 1'b0);
    hwr(2'd0, 8'h00);
    pkt_done = 1'b1; host_rd = 1'b1; host_reg = 2'd3;
    tick(1); pkt_done = 1'b0; host_rd = 1'b0; tick(2);
    check("R9 clear wins", hirq_flag, 1'b0);

    // R10 microprocessor interrupt mix
    lclr(0); lwr(8'h04); shdc_flag = 1'b1; tick(2);
    check("R10 shadow on", uproc_irq_n, 1'b0);
    lwr(8'h00); check("R10 shadow masked", uproc_irq_n, 1'b1);
    shdc_flag = 1'b0; hwr(2'd2, 8'h90);
    check("R10 hif masked", uproc_irq_n, 1'b1);
    lwr(8'h80); check("R10 hif enabled", uproc_irq_n, 1'b0);

    finish_run();
  end
endmodule